// File: doc/BRIEF.md
# Array and Control-Register Write Guard

This block sits between the command decoder of a serial memory and its nonvolatile array. It owns an 8-bit control register mapped at the all-ones address of a 16-bit address space. For every write transaction it decides, once the transaction ends, whether the write may go ahead. There are three possible outcomes: the array write is granted, the register write is committed, or the transaction is aborted.

The control register has two jobs. It holds a two-bit segment selector that fences off the top quarter, the top half or all of the array, working down from the highest address. It also holds a lock-enable bit. When the lock-enable bit is 1 and the write-protect pin is held low, the register cannot be rewritten at all. The register may only be written with exactly one byte. A read of the register address returns the register byte first and zeros after that.

The controller is a four-state machine. ST_IDLE waits for a transaction start. The start moves it to ST_REG_WR for a write to the register address, to ST_ARR_WR for a write to any other address, or to ST_READ for any read. A stop strobe returns any state to ST_IDLE, and the outcome pulse is produced on that transition. A new start seen in any state before the stop re-targets the machine from the fresh address.

Top module: `wr_guard`

## Requirements
- R1: A register write transaction that carries two or more data bytes ends with an abort pulse and no commit, and the register keeps its old value.
- R2: Register bit 7 is the lock-enable bit and bits 3:2 are the segment selector. Bits 6:4 and 1:0 are stored as 0 whatever is written, and they read back as 0.
- R3: In a read of the register address, the first byte on `rd_data_o` is the register value and every later byte is 00h. A read of any other address shows 00h.
- R4: Hardware lock is active exactly when `wp_pin_i` is 0 and register bit 7 is 1. While it is active, every single-byte register write is refused with an abort. With the pin high, register writes are accepted even when bit 7 is 1.
- R5: While the hardware lock is active, a write that would clear bit 7 is refused, so bit 7 stays 1.
- R6: The segment selector uses the top two bits of the low `ARR_AW` address bits (the upper address bits are ignored). Selector 00 protects nothing. Selector 01 protects addresses whose top two bits are 11. Selector 10 protects addresses whose top bit is 1. Selector 11 protects the whole array. With `ARR_AW`=11 these ranges are 0600h–07FFh, 0400h–07FFh and 0000h–07FFh.
- R7: An array write of at least one byte to a protected start address aborts with no grant. An array write to an unprotected address is granted, whether or not the hardware lock is active.
- R8: A register write commits only when exactly one byte arrived before the stop. The new value reads back from the cycle after the stop edge, together with the commit pulse. A write transaction with no data bytes produces no pulse at all.
- R9: The grant, commit and abort outputs are single-cycle pulses. They appear in the cycle after the stop edge, and at most one of them is high at a time.
- R10: During reset the register loads `preset_i`, with the unused bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset_i | input | 8 | Stored register value loaded during reset |
| txn_start_i | input | 1 | Transaction start strobe; address and direction are sampled with it |
| txn_write_i | input | 1 | 1 for a write transaction, 0 for a read |
| txn_stop_i | input | 1 | Transaction end strobe |
| addr_i | input | 16 | Target address of the transaction |
| byte_vld_i | input | 1 | One data byte transferred this cycle |
| byte_data_i | input | 8 | Write data byte |
| wp_pin_i | input | 1 | Write-protect pin, low means asserted |
| arr_grant_o | output | 1 | Array write granted (pulse) |
| reg_commit_o | output | 1 | Register write committed (pulse) |
| abort_o | output | 1 | Write refused (pulse) |
| rd_data_o | output | 8 | Read data for register reads |

## Verification
The assertions assume a well-formed upstream decoder. The start, stop and byte strobes never coincide in one cycle. A stop is only issued after a start. The pin is stable around a stop edge. The bench drives each transaction as a start cycle, then one cycle per byte, then a stop cycle, followed by an idle gap. It never overlaps these strobes. A behavioural model replays the same input sequence and predicts all four outputs every cycle.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REG_WR,
        ST_ARR_WR,
        ST_READ
    } guard_state_e;

    localparam int          CREG_W    = 8;
    localparam int          LOCK_POS  = 7;
    localparam int          SEG_LSB   = 2;
    localparam logic [7:0]  CREG_KEEP = 8'h8C;

endpackage

// File: rtl/wr_guard_seg.sv
module wr_guard_seg #(
    parameter int ARR_AW = 11
) (
    input  logic [1:0]        seg_sel_i,
    input  logic [ARR_AW-1:0] arr_addr_i,
    output logic              in_prot_o
);
    localparam int TOP = ARR_AW - 1;

    logic [1:0] top_bits;
    assign top_bits = arr_addr_i[TOP -: 2];

    always_comb begin
        unique case (seg_sel_i)
            2'b00:   in_prot_o = 1'b0;
            2'b01:   in_prot_o = (top_bits == 2'b11);
            2'b10:   in_prot_o = top_bits[1];
            default: in_prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wr_guard_creg.sv
module wr_guard_creg
    import wr_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CREG_W-1:0] preset_i,
    input  logic              wr_en_i,
    input  logic [CREG_W-1:0] wr_data_i,
    output logic [CREG_W-1:0] value_o,
    output logic              lock_en_o,
    output logic [1:0]        seg_sel_o
);
    logic [CREG_W-1:0] creg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            creg_q <= preset_i & CREG_KEEP;
        else if (wr_en_i)
            creg_q <= wr_data_i & CREG_KEEP;
    end

    assign value_o   = creg_q;
    assign lock_en_o = creg_q[LOCK_POS];
    assign seg_sel_o = creg_q[SEG_LSB +: 2];

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(creg_q)); // R8
endmodule

// File: rtl/wr_guard.sv
module wr_guard
    import wr_guard_pkg::*;
#(
    parameter int ARR_AW = 11,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        preset_i,
    input  logic              txn_start_i,
    input  logic              txn_write_i,
    input  logic              txn_stop_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_data_i,
    input  logic              wp_pin_i,
    output logic              arr_grant_o,
    output logic              reg_commit_o,
    output logic              abort_o,
    output logic [7:0]        rd_data_o
);
    localparam logic [ADDR_W-1:0] CREG_ADDR = '1;
    localparam logic [1:0]        CNT_MANY  = 2'd2;

    guard_state_e      state_q, state_d;
    logic [1:0]        cnt_q;
    logic [7:0]        first_q;
    logic [ADDR_W-1:0] addr_q;
    logic              grant_q, commit_q, abort_q;

    logic [7:0]        creg_val;
    logic              lock_en;
    logic [1:0]        seg_sel;
    logic              seg_prot;
    logic              hw_lock;
    logic              creg_wr;
    logic              in_txn;

    wr_guard_creg u_creg (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset_i  (preset_i),
        .wr_en_i   (creg_wr),
        .wr_data_i (first_q),
        .value_o   (creg_val),
        .lock_en_o (lock_en),
        .seg_sel_o (seg_sel)
    );

    wr_guard_seg #(.ARR_AW(ARR_AW)) u_seg (
        .seg_sel_i  (seg_sel),
        .arr_addr_i (addr_q[ARR_AW-1:0]),
        .in_prot_o  (seg_prot)
    );

    assign hw_lock = !wp_pin_i && lock_en;
    assign in_txn  = (state_q != ST_IDLE);
    assign creg_wr = txn_stop_i && (state_q == ST_REG_WR)
                     && (cnt_q == 2'd1) && !hw_lock;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_REG_WR, ST_ARR_WR, ST_READ: begin
                if (txn_stop_i)
                    state_d = ST_IDLE;
                else if (txn_start_i) begin
                    if (!txn_write_i)            state_d = ST_READ;
                    else if (addr_i == CREG_ADDR) state_d = ST_REG_WR;
                    else                          state_d = ST_ARR_WR;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // transaction bookkeeping: address, saturating byte count, first byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= '0;
            addr_q  <= '0;
        end else if (txn_start_i && !txn_stop_i) begin
            cnt_q  <= '0;
            addr_q <= addr_i;
        end else if (byte_vld_i && in_txn) begin
            if (cnt_q == 2'd0) first_q <= byte_data_i;
            if (cnt_q != CNT_MANY) cnt_q <= cnt_q + 2'd1;
        end
    end

    // outcome pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q  <= 1'b0;
            commit_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            grant_q  <= 1'b0;
            commit_q <= 1'b0;
            abort_q  <= 1'b0;
            if (txn_stop_i && cnt_q != 2'd0) begin
                unique case (state_q)
                    ST_REG_WR: begin
                        commit_q <= creg_wr;
                        abort_q  <= !creg_wr;
                    end
                    ST_ARR_WR: begin
                        grant_q <= !seg_prot;
                        abort_q <= seg_prot;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign arr_grant_o  = grant_q;
    assign reg_commit_o = commit_q;
    assign abort_o      = abort_q;
    assign rd_data_o    = (state_q == ST_READ && addr_q == CREG_ADDR && cnt_q == 2'd0)
                          ? creg_val : 8'h00;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_grant_o, reg_commit_o, abort_o})); // R9
    AST_MULTI_BYTE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REG_WR && txn_stop_i && cnt_q == CNT_MANY)
        |=> (abort_o && !reg_commit_o)); // R1
    AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en && !wp_pin_i) |=> lock_en); // R5
    AST_PROT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant_o |-> $past(!seg_prot)); // R7
    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_stop_i && cnt_q == 2'd0) |=> !(arr_grant_o || reg_commit_o || abort_o)); // R8
endmodule

// File: tb/wr_guard_tb.sv
module wr_guard_tb;
    localparam int AW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  preset = 8'hFF;
    logic        start = 0, wr = 0, stop = 0, bvld = 0, wp = 1;
    logic [15:0] addr = '0;
    logic [7:0]  bdata = '0;
    logic        grant, commit, abort_s;
    logic [7:0]  rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    wr_guard #(.ARR_AW(AW), .ADDR_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .preset_i(preset),
        .txn_start_i(start), .txn_write_i(wr), .txn_stop_i(stop),
        .addr_i(addr), .byte_vld_i(bvld), .byte_data_i(bdata),
        .wp_pin_i(wp), .arr_grant_o(grant), .reg_commit_o(commit),
        .abort_o(abort_s), .rd_data_o(rdata)
    );

    // ---------------- behavioural reference model ----------------
    int          m_mode;   // 0 idle, 1 register write, 2 array write, 3 read
    int          m_bytes;
    logic [7:0]  m_first;
    logic [15:0] m_addr;
    logic [7:0]  m_reg;
    logic        e_grant, e_commit, e_abort;

    function automatic bit ref_prot(input logic [15:0] a, input logic [7:0] r);
        int top;
        top = int'(a[AW-1 -: 2]);
        case (r[3:2])
            2'd0:    return 0;
            2'd1:    return top == 3;
            2'd2:    return top >= 2;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_bytes = 0; m_first = 0; m_addr = 0;
            m_reg = preset & 8'h8C;
            e_grant = 0; e_commit = 0; e_abort = 0;
        end else begin
            e_grant = 0; e_commit = 0; e_abort = 0;
            if (stop) begin
                if (m_mode == 1 && m_bytes > 0) begin
                    if (m_bytes == 1 && !(!wp && m_reg[7])) begin
                        e_commit = 1; m_reg = m_first & 8'h8C;
                    end else e_abort = 1;
                end else if (m_mode == 2 && m_bytes > 0) begin
                    if (ref_prot(m_addr, m_reg)) e_abort = 1;
                    else e_grant = 1;
                end
                m_mode = 0;
            end else if (start) begin
                m_mode  = !wr ? 3 : (addr == 16'hFFFF ? 1 : 2);
                m_bytes = 0; m_addr = addr;
            end else if (bvld && m_mode != 0) begin
                if (m_bytes == 0) m_first = bdata;
                m_bytes++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e_rd;
            e_rd = (m_mode == 3 && m_addr == 16'hFFFF && m_bytes == 0) ? m_reg : 8'h00;
            chk(grant == e_grant,    "R7 grant",   grant,   e_grant);
            chk(commit == e_commit,  "R8 commit",  commit,  e_commit);
            chk(abort_s == e_abort,  "R9 abort",   abort_s, e_abort);
            chk(rdata == e_rd,       "R3 rd_data", rdata,   e_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic write_txn(input logic [15:0] a, input int n, input logic [7:0] d,
                             input bit eg, input bit ec, input bit ea, input string tag);
        start = 1; wr = 1; addr = a; tick(); start = 0;
        for (int k = 0; k < n; k++) begin
            bvld = 1; bdata = d + 8'(k); tick();
        end
        bvld = 0; stop = 1; tick(); stop = 0;
        @(negedge clk);
        chk({grant, commit, abort_s} == {eg, ec, ea}, tag,
            {grant, commit, abort_s}, {eg, ec, ea});
        tick();
        @(negedge clk);
        chk({grant, commit, abort_s} == 3'b000, "R9 pulse width",
            {grant, commit, abort_s}, 0);
        tick();
    endtask

    task automatic read_txn(input logic [15:0] a, input logic [7:0] exp, input string tag);
        start = 1; wr = 0; addr = a; tick(); start = 0;
        @(negedge clk);
        chk(rdata == exp, tag, rdata, exp);
        tick(); bvld = 1; bdata = 8'h5A; tick(); bvld = 0;
        @(negedge clk);
        chk(rdata == 8'h00, "R3 later read byte", rdata, 0);
        tick(); stop = 1; tick(); stop = 0; tick();
    endtask

    initial begin
        logic [15:0] alist [8];
        alist = '{16'h0000, 16'h03FF, 16'h0400, 16'h05FF,
                  16'h0600, 16'h07FF, 16'hF9FF, 16'hFE00};
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        tick();
        read_txn(16'hFFFF, 8'h8C, "R10 preset masked");
        // hardware lock active: register write refused, lock bit sticks
        wp = 0;
        write_txn(16'hFFFF, 1, 8'h00, 0, 0, 1, "R5 clear lock refused");
        read_txn(16'hFFFF, 8'h8C, "R5 lock still set");
        write_txn(16'h0010, 1, 8'h11, 0, 0, 1, "R7 full array protected");
        // pin high releases lock
        wp = 1;
        write_txn(16'hFFFF, 1, 8'h00, 0, 1, 0, "R4 pin high accepts");
        read_txn(16'hFFFF, 8'h00, "R8 committed value");
        write_txn(16'hFFFF, 2, 8'h84, 0, 0, 1, "R1 two bytes aborted");
        read_txn(16'hFFFF, 8'h00, "R1 register unchanged");
        write_txn(16'hFFFF, 1, 8'hFF, 0, 1, 0, "R2 write all ones");
        read_txn(16'hFFFF, 8'h8C, "R2 unused bits zero");
        write_txn(16'hFFFF, 0, 8'h00, 0, 0, 0, "R8 zero byte silent");
        // segment map sweep with lock bit clear
        for (int bp = 0; bp < 4; bp++) begin
            write_txn(16'hFFFF, 1, 8'(bp << 2), 0, 1, 0, "R6 set selector");
            for (int i = 0; i < 8; i++) begin
                bit p;
                p = ref_prot(alist[i], 8'(bp << 2));
                write_txn(alist[i], 1, 8'hA5, !p, 0, p, "R6 segment map");
            end
        end
        // lock active with quarter protection: unprotected array still writable
        write_txn(16'hFFFF, 1, 8'h84, 0, 1, 0, "R4 set lock and quarter");
        wp = 0;
        write_txn(16'h0100, 2, 8'h22, 1, 0, 0, "R7 unprotected under lock");
        write_txn(16'h0700, 1, 8'h33, 0, 0, 1, "R7 protected under lock");
        write_txn(16'hFFFF, 1, 8'h00, 0, 0, 1, "R4 register refused");
        read_txn(16'hFFFF, 8'h84, "R4 register kept");
        read_txn(16'h0123, 8'h00, "R3 array read shows zero");
        wp = 1;
        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule